// File: doc/BRIEF.md
# NAND Storage Array Emulator

This block is a synthesizable, scaled-down stand-in for a single-level-cell NAND storage array. It is used to exercise flash controller logic in simulation or on a prototype, without a real device. Storage is organised as blocks. Each block holds pages, and each page carries a data area followed by a spare area one thirty-second of its size. A plain command port takes one of three operations: page read, page program or block erase. Page data moves over two byte-wide valid/ready streams. A busy flag and a done/fail status report progress and result.

The emulator keeps the one-way bit rule. Programming can only pull bits to 0, and only an erase brings them back to 1. Each page accepts a bounded number of partial programs between erases. Reads are tallied per block, and a warning is raised once the tally passes a threshold. A per-block fault input makes program and erase report failure so that a controller's error paths can be driven.

Back-pressure rules: on the write stream, a byte is taken on each rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while a program is collecting its page. On the read stream, a byte leaves on each edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid` and `rd_data` hold. Either side may stall for any number of cycles.

Top module: `nand_array_emu`

## Requirements
- R1: After reset, `busy`, `done` and every `rd_warn` bit are 0, and every byte of every page reads back as 0xFF.
- R2: Command code 2'b10 programs one page. The page takes exactly `DATA_BYTES + DATA_BYTES/32` bytes from the write stream. The stored value is the bitwise AND of the old byte and the new byte, so a 0 bit never returns to 1 through programming.
- R3: Command code 2'b11 erases one block. Every byte of every page in that block becomes 0xFF, spare bytes included, and no other block changes.
- R4: Command code 2'b01 reads one page on the read stream, in order from byte 0. Bytes 0 to `DATA_BYTES-1` are data and the bytes after them are spare. The read ends with `done` high and `fail` low after exactly one page of bytes. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds.
- R5: A page accepts at most `NOP` (default 4) successful programs between erases. Any further program still takes the full page from the stream, then reports `fail` and leaves the page unchanged.
- R6: Each block counts its successful reads since its last successful erase. `rd_warn[b]` is high exactly when block b's count is greater than `rd_warn_limit`.
- R7: If `fail_inject[b]` is high when a program or erase of block b is accepted, the operation reports `fail` and no stored byte changes.
- R8: A command is accepted only when `busy` is low. `busy` rises the cycle after acceptance and drops in the same cycle that `done` pulses. The first read byte is offered `T_READ` cycles after the accepting edge. A program pulses `done` `T_PROG` cycles after the edge that takes its last byte. An erase pulses `done` `PAGES*(DATA_BYTES+DATA_BYTES/32) + T_ERASE` cycles after acceptance, or `T_ERASE` cycles after acceptance when it is fault-injected. Commands presented while busy are ignored.
- R9: A read or program with block ≥ `BLOCKS` or page ≥ `PAGES`, and an erase with block ≥ `BLOCKS`, pulse `done` with `fail` high on the next cycle. They touch no storage or counters and leave `busy` low.
- R10: The read count and the program counts of a block are cleared only by a successful erase of that block. A failed erase leaves them as they were.
- R11: Command code 2'b00 is ignored: no `busy`, no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 00 none, 01 read, 10 program, 11 erase |
| cmd_blk | input | $clog2(BLOCKS)+1 | Block address (one spare bit so out-of-range values are expressible) |
| cmd_page | input | $clog2(PAGES)+1 | Page address within the block |
| fail_inject | input | BLOCKS | Per-block fault request for program and erase |
| rd_warn_limit | input | RD_CNT_W | Read-count threshold for the warning |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte accepted |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream sink ready |
| rd_data | output | 8 | Read stream byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last completed operation |
| rd_warn | output | BLOCKS | Per-block read-disturb warning |

## Verification
A corrupted page counter would go unnoticed until the fifth program of a page. That program would then pass where it should fail, or an earlier one would fail, and the mismatch shows in `fail` at that program's `done`. A bad address computation or a missed AND shows on the first read of the affected page as a wrong byte at a known stream position. A stuck erase sweep shows as a wrong `done` cycle or as non-0xFF bytes in a later read. A read counter that is not cleared, or is cleared by a failed erase, shows on `rd_warn` right after the erase completes.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } nand_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RWAIT,
    S_RSTREAM,
    S_LOAD,
    S_PWAIT,
    S_ESWEEP,
    S_EWAIT
  } nand_state_e;

endpackage

// File: rtl/nand_cell_ram.sv
// Byte array with one access per cycle; write either ANDs new data in or
// fills the byte with all ones.
module nand_cell_ram #(
  parameter int DEPTH = 2112,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          fill,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[addr] <= fill ? 8'hFF : (cells[addr] & wdata);
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/nand_wear_track.sv
// Per-block read tallies and per-page partial-program tallies.
module nand_wear_track #(
  parameter int BLOCKS   = 4,
  parameter int PAGES    = 16,
  parameter int NOP      = 4,
  parameter int RD_CNT_W = 16,
  localparam int BW      = $clog2(BLOCKS),
  localparam int PW      = $clog2(PAGES),
  localparam int NOP_W   = $clog2(NOP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BW-1:0]       sel_blk,
  input  logic [PW-1:0]       sel_pg,
  input  logic                rd_hit,
  input  logic                prog_hit,
  input  logic                clr_hit,
  input  logic [RD_CNT_W-1:0] limit,
  output logic [NOP_W-1:0]    pcnt_o,
  output logic [BLOCKS-1:0]   warn_o
);

  logic [BLOCKS-1:0][NOP_W-1:0] blk_pcnt;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    logic [RD_CNT_W-1:0] rcnt;
    logic [NOP_W-1:0]    pcnt [PAGES];
    logic                hit;

    assign hit = (sel_blk == BW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rcnt <= '0;
        for (int p = 0; p < PAGES; p++) pcnt[p] <= '0;
      end else if (clr_hit && hit) begin
        rcnt <= '0;
        for (int p = 0; p < PAGES; p++) pcnt[p] <= '0;
      end else begin
        if (rd_hit && hit && (rcnt != '1)) rcnt <= rcnt + 1'b1;
        if (prog_hit && hit) pcnt[sel_pg] <= pcnt[sel_pg] + 1'b1;
      end
    end

    assign warn_o[b]   = (rcnt > limit);
    assign blk_pcnt[b] = pcnt[sel_pg];
  end

  assign pcnt_o = blk_pcnt[sel_blk];

endmodule

// File: rtl/nand_seq.sv
// Command sequencer: decodes commands, runs the stream transfers, the
// erase sweep and the busy timers, and reports status.
module nand_seq
  import nand_emu_pkg::*;
#(
  parameter int BLOCKS     = 4,
  parameter int PAGES      = 16,
  parameter int DATA_BYTES = 32,
  parameter int NOP        = 4,
  parameter int T_READ     = 4,
  parameter int T_PROG     = 12,
  parameter int T_ERASE    = 20,
  localparam int PAGE_BYTES  = DATA_BYTES + DATA_BYTES / 32,
  localparam int BLOCK_BYTES = PAGES * PAGE_BYTES,
  localparam int DEPTH       = BLOCKS * BLOCK_BYTES,
  localparam int MEM_AW      = $clog2(DEPTH),
  localparam int BW          = $clog2(BLOCKS),
  localparam int PW          = $clog2(PAGES),
  localparam int BLK_AW      = BW + 1,
  localparam int PG_AW       = PW + 1,
  localparam int IW          = $clog2(BLOCK_BYTES),
  localparam int NOP_W       = $clog2(NOP + 1),
  localparam int T_MAX       = (T_ERASE > T_PROG) ?
                               ((T_ERASE > T_READ) ? T_ERASE : T_READ) :
                               ((T_PROG > T_READ) ? T_PROG : T_READ),
  localparam int TW          = $clog2(T_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_AW-1:0] cmd_blk,
  input  logic [PG_AW-1:0]  cmd_page,
  input  logic [BLOCKS-1:0] fail_inject,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [MEM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_fill,
  output logic [BW-1:0]     trk_blk,
  output logic [PW-1:0]     trk_pg,
  output logic              trk_rd,
  output logic              trk_prog,
  output logic              trk_clr,
  input  logic [NOP_W-1:0]  trk_pcnt
);

  nand_state_e       state;
  logic [BW-1:0]     cur_blk;
  logic [PW-1:0]     cur_pg;
  logic [IW-1:0]     idx;
  logic [TW-1:0]     timer;
  logic              doomed;
  logic              done_q;
  logic              fail_q;

  logic              in_blk, in_pg;
  logic [BW-1:0]     cmd_blk_lo;
  logic [PW-1:0]     cmd_pg_lo;
  logic              last_pg, last_blk;

  assign in_blk     = (cmd_blk < BLK_AW'(BLOCKS));
  assign in_pg      = (cmd_page < PG_AW'(PAGES));
  assign cmd_blk_lo = cmd_blk[BW-1:0];
  assign cmd_pg_lo  = cmd_page[PW-1:0];
  assign last_pg    = (idx == IW'(PAGE_BYTES - 1));
  assign last_blk   = (idx == IW'(BLOCK_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_blk <= '0;
      cur_pg  <= '0;
      idx     <= '0;
      timer   <= '0;
      doomed  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            case (nand_op_e'(cmd_op))
              OP_READ: begin
                if (in_blk && in_pg) begin
                  cur_blk <= cmd_blk_lo;
                  cur_pg  <= cmd_pg_lo;
                  timer   <= TW'(T_READ - 1);
                  state   <= S_RWAIT;
                end else begin
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
                end
              end
              OP_PROG: begin
                if (in_blk && in_pg) begin
                  cur_blk <= cmd_blk_lo;
                  cur_pg  <= cmd_pg_lo;
                  idx     <= '0;
                  doomed  <= fail_inject[cmd_blk_lo] || (trk_pcnt >= NOP_W'(NOP));
                  state   <= S_LOAD;
                end else begin
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
                end
              end
              OP_ERASE: begin
                if (in_blk) begin
                  cur_blk <= cmd_blk_lo;
                  idx     <= '0;
                  doomed  <= fail_inject[cmd_blk_lo];
                  if (fail_inject[cmd_blk_lo]) begin
                    timer <= TW'(T_ERASE - 1);
                    state <= S_EWAIT;
                  end else begin
                    state <= S_ESWEEP;
                  end
                end else begin
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        S_RWAIT: begin
          if (timer == '0) begin
            idx   <= '0;
            state <= S_RSTREAM;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_RSTREAM: begin
          if (rd_ready) begin
            if (last_pg) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              fail_q <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_LOAD: begin
          if (wr_valid) begin
            if (last_pg) begin
              timer <= TW'(T_PROG - 1);
              state <= S_PWAIT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_ESWEEP: begin
          if (last_blk) begin
            timer <= TW'(T_ERASE - 1);
            state <= S_EWAIT;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PWAIT, S_EWAIT: begin
          if (timer == '0) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            fail_q <= doomed;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state == S_ESWEEP)
      ram_addr = MEM_AW'(int'(cur_blk) * BLOCK_BYTES + int'(idx));
    else
      ram_addr = MEM_AW'((int'(cur_blk) * PAGES + int'(cur_pg)) * PAGE_BYTES + int'(idx));
  end

  assign ram_we   = ((state == S_LOAD) && wr_valid && !doomed) || (state == S_ESWEEP);
  assign ram_fill = (state == S_ESWEEP);

  assign trk_blk  = (state == S_IDLE) ? cmd_blk_lo : cur_blk;
  assign trk_pg   = (state == S_IDLE) ? cmd_pg_lo  : cur_pg;
  assign trk_rd   = (state == S_IDLE) && cmd_valid && (cmd_op == OP_READ) && in_blk && in_pg;
  assign trk_prog = (state == S_LOAD) && wr_valid && last_pg && !doomed;
  assign trk_clr  = (state == S_ESWEEP) && last_blk;

  assign wr_ready = (state == S_LOAD);
  assign rd_valid = (state == S_RSTREAM);
  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign fail     = fail_q;

endmodule

// File: rtl/nand_array_emu.sv
module nand_array_emu #(
  parameter int BLOCKS     = 4,
  parameter int PAGES      = 16,
  parameter int DATA_BYTES = 32,
  parameter int NOP        = 4,
  parameter int RD_CNT_W   = 16,
  parameter int T_READ     = 4,
  parameter int T_PROG     = 12,
  parameter int T_ERASE    = 20,
  localparam int PAGE_BYTES = DATA_BYTES + DATA_BYTES / 32,
  localparam int DEPTH      = BLOCKS * PAGES * PAGE_BYTES,
  localparam int MEM_AW     = $clog2(DEPTH),
  localparam int BW         = $clog2(BLOCKS),
  localparam int PW         = $clog2(PAGES),
  localparam int NOP_W      = $clog2(NOP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [BW:0]         cmd_blk,
  input  logic [PW:0]         cmd_page,
  input  logic [BLOCKS-1:0]   fail_inject,
  input  logic [RD_CNT_W-1:0] rd_warn_limit,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [7:0]          wr_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [7:0]          rd_data,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [BLOCKS-1:0]   rd_warn
);

  logic [MEM_AW-1:0] ram_addr;
  logic              ram_we, ram_fill;
  logic [BW-1:0]     trk_blk;
  logic [PW-1:0]     trk_pg;
  logic              trk_rd, trk_prog, trk_clr;
  logic [NOP_W-1:0]  trk_pcnt;

  nand_seq #(
    .BLOCKS(BLOCKS), .PAGES(PAGES), .DATA_BYTES(DATA_BYTES), .NOP(NOP),
    .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .fail_inject(fail_inject),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .busy(busy), .done(done), .fail(fail),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_fill(ram_fill),
    .trk_blk(trk_blk), .trk_pg(trk_pg), .trk_rd(trk_rd), .trk_prog(trk_prog),
    .trk_clr(trk_clr), .trk_pcnt(trk_pcnt)
  );

  nand_cell_ram #(.DEPTH(DEPTH), .AW(MEM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .addr(ram_addr), .we(ram_we), .fill(ram_fill),
    .wdata(wr_data), .rdata(rd_data)
  );

  nand_wear_track #(
    .BLOCKS(BLOCKS), .PAGES(PAGES), .NOP(NOP), .RD_CNT_W(RD_CNT_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .sel_blk(trk_blk), .sel_pg(trk_pg),
    .rd_hit(trk_rd), .prog_hit(trk_prog), .clr_hit(trk_clr),
    .limit(rd_warn_limit), .pcnt_o(trk_pcnt), .warn_o(rd_warn)
  );

endmodule

// File: rtl/nand_array_emu_chk.sv
module nand_array_emu_chk #(
  parameter int BLOCKS   = 4,
  parameter int PAGES    = 16,
  localparam int BW      = $clog2(BLOCKS),
  localparam int PW      = $clog2(PAGES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [BW:0]   cmd_blk,
  input logic [PW:0]   cmd_page,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic          busy,
  input logic          done,
  input logic          fail
);

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_one_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));

  p_stream_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready) |-> busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_bad_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 2'b01 && (cmd_blk >= BLOCKS || cmd_page >= PAGES))
    |=> (done && fail && !busy));

  p_noop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 2'b00) |=> (!busy && !done));

endmodule

bind nand_array_emu nand_array_emu_chk #(.BLOCKS(BLOCKS), .PAGES(PAGES)) u_chk (.*);

// File: tb/test_nand_array_emu.sv
`timescale 1ns/1ps
module test_nand_array_emu;

  localparam int BLOCKS = 4;
  localparam int PAGES  = 16;
  localparam int DB     = 32;
  localparam int PB     = DB + DB / 32;
  localparam int BB     = PAGES * PB;
  localparam int NOP    = 4;
  localparam int T_READ = 4;
  localparam int T_PROG = 12;
  localparam int T_ERASE = 20;
  localparam int BW = $clog2(BLOCKS);
  localparam int PW = $clog2(PAGES);

  logic              clk, rst_n;
  logic              cmd_valid;
  logic [1:0]        cmd_op;
  logic [BW:0]       cmd_blk;
  logic [PW:0]       cmd_page;
  logic [BLOCKS-1:0] fail_inject;
  logic [15:0]       rd_warn_limit;
  logic              wr_valid, wr_ready;
  logic [7:0]        wr_data;
  logic              rd_valid, rd_ready;
  logic [7:0]        rd_data;
  logic              busy, done, fail;
  logic [BLOCKS-1:0] rd_warn;

  nand_array_emu i_nand_array_emu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page), .fail_inject(fail_inject),
    .rd_warn_limit(rd_warn_limit), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .fail(fail), .rd_warn(rd_warn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] model [BLOCKS*BB];
  int pcnt [BLOCKS*PAGES];
  int rcnt [BLOCKS];
  logic [7:0] exp_q [$];
  int mon_cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 13) ^ (i << 3) ^ (seed << 5));
  endfunction

  // Monitor: drives back-pressure, pops the scoreboard on every read beat.
  initial begin
    rd_ready = 1'b0;
    forever begin
      @(negedge clk);
      mon_cyc++;
      rd_ready = (mon_cyc % 3) != 2;
      #1;
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected read byte", int'(rd_data), 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R2/R3/R4", "read byte", int'(rd_data), int'(e));
        end
      end
    end
  end

  task automatic send_cmd(input logic [1:0] op, input int blk, input int pg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_blk   = (BW+1)'(blk);
    cmd_page  = (PW+1)'(pg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_bad(input string req);
    check(done && fail && !busy, req, "out-of-range status {done,fail,busy}",
          int'({done, fail, busy}), 3'b110);
  endtask

  task automatic do_read(input int blk, input int pg, input bit poke);
    bit bad;
    int n;
    bad = (blk >= BLOCKS) || (pg >= PAGES);
    if (!bad) begin
      for (int i = 0; i < PB; i++) exp_q.push_back(model[blk*BB + pg*PB + i]);
      rcnt[blk]++;
    end
    send_cmd(2'b01, blk, pg);
    if (bad) begin
      check_bad("R9");
      return;
    end
    n = 0;
    if (poke) begin
      cmd_valid = 1'b1; cmd_op = 2'b11; cmd_blk = 3'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 1;
    end
    while (!rd_valid) begin @(negedge clk); n++; end
    check(n == T_READ, "R8", "read latency", n, T_READ);
    while (!done) @(negedge clk);
    check(!fail, "R4", "read status", int'(fail), 0);
    check(exp_q.size() == 0, "R4", "bytes left after read", exp_q.size(), 0);
  endtask

  task automatic do_prog(input int blk, input int pg, input int seed);
    bit bad, xfail;
    int m;
    logic [7:0] d [PB];
    bad = (blk >= BLOCKS) || (pg >= PAGES);
    send_cmd(2'b10, blk, pg);
    if (bad) begin
      check_bad("R9");
      return;
    end
    xfail = fail_inject[blk] || (pcnt[blk*PAGES + pg] >= NOP);
    for (int i = 0; i < PB; i++) begin
      d[i] = pat(seed, i);
      if (i % 7 == 3) begin wr_valid = 1'b0; @(negedge clk); end
      wr_valid = 1'b1;
      wr_data  = d[i];
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    m = 0;
    while (!done) begin @(negedge clk); m++; end
    check(m == T_PROG, "R8", "program busy tail", m, T_PROG);
    check(fail == xfail, "R5/R7", "program status", int'(fail), int'(xfail));
    if (!xfail) begin
      for (int i = 0; i < PB; i++) model[blk*BB + pg*PB + i] &= d[i];
      pcnt[blk*PAGES + pg]++;
    end
  endtask

  task automatic do_erase(input int blk);
    bit xfail;
    int m, exp_m;
    send_cmd(2'b11, blk, 0);
    if (blk >= BLOCKS) begin
      check_bad("R9");
      return;
    end
    xfail = fail_inject[blk];
    exp_m = xfail ? T_ERASE : BB + T_ERASE;
    m = 0;
    while (!done) begin @(negedge clk); m++; end
    check(m == exp_m, "R8", "erase duration", m, exp_m);
    check(fail == xfail, "R3/R7", "erase status", int'(fail), int'(xfail));
    if (!xfail) begin
      for (int i = 0; i < BB; i++) model[blk*BB + i] = 8'hFF;
      for (int p = 0; p < PAGES; p++) pcnt[blk*PAGES + p] = 0;
      rcnt[blk] = 0;
    end
  endtask

  task automatic check_warn(input string req);
    logic [BLOCKS-1:0] e;
    for (int b = 0; b < BLOCKS; b++) e[b] = (rcnt[b] > int'(rd_warn_limit));
    check(rd_warn == e, req, "rd_warn", int'(rd_warn), int'(e));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < BLOCKS*BB; i++) model[i] = 8'hFF;
    for (int i = 0; i < BLOCKS*PAGES; i++) pcnt[i] = 0;
    for (int b = 0; b < BLOCKS; b++) rcnt[b] = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_blk = '0; cmd_page = '0;
    fail_inject = '0; rd_warn_limit = 16'd2; wr_valid = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && rd_warn == '0, "R1", "reset {busy,done,warn}",
          int'({busy, done, rd_warn}), 0);
    do_read(0, 0, 1'b0);   // R1 erased contents
    do_read(3, 15, 1'b0);  // R1, spare byte included

    // R2: AND programming
    do_prog(0, 0, 1);
    do_read(0, 0, 1'b0);
    do_prog(0, 0, 2);
    do_read(0, 0, 1'b0);
    do_prog(1, 5, 3);
    do_read(1, 5, 1'b0);

    // R5: partial program limit
    do_prog(0, 0, 4);
    do_prog(0, 0, 5);
    do_prog(0, 0, 6);      // fifth attempt: must fail
    do_read(0, 0, 1'b0);

    // R3: erase block 0 only
    do_erase(0);
    do_read(0, 0, 1'b0);
    do_read(1, 5, 1'b0);
    do_prog(0, 0, 7);      // R10: counts cleared by good erase
    do_read(0, 0, 1'b0);

    // R7: fault injection on block 1
    fail_inject = 4'b0010;
    do_prog(1, 5, 8);
    do_erase(1);
    do_read(1, 5, 1'b0);
    fail_inject = '0;

    // R9: out-of-range addresses
    do_read(4, 0, 1'b0);
    do_read(0, 16, 1'b0);
    do_prog(5, 0, 9);
    do_erase(6);
    @(negedge clk);
    check(!busy && !done, "R9", "idle after bad address", int'({busy, done}), 0);

    // R11: no-op code
    send_cmd(2'b00, 0, 0);
    check(!busy && !done, "R11", "no-op {busy,done}", int'({busy, done}), 0);
    @(negedge clk);
    check(!busy && !done, "R11", "no-op later {busy,done}", int'({busy, done}), 0);

    // R6: read-disturb warning on block 3 (one read already made)
    check_warn("R6");
    do_read(3, 0, 1'b0);
    check_warn("R6");
    do_read(3, 1, 1'b0);
    check_warn("R6");
    check(rd_warn[3] == 1'b1, "R6", "warn after threshold", int'(rd_warn[3]), 1);

    // R10: failed erase keeps read and program tallies
    fail_inject = 4'b1000;
    do_erase(3);
    check_warn("R10");
    fail_inject = 4'b0100;
    for (int k = 0; k < 4; k++) begin
      fail_inject = '0;
      do_prog(2, 1, 20 + k);
    end
    fail_inject = 4'b0100;
    do_erase(2);
    fail_inject = '0;
    do_prog(2, 1, 30);     // R10: still counted, must fail
    do_read(2, 1, 1'b0);
    do_erase(2);
    do_prog(2, 1, 31);     // R10: cleared by good erase
    do_read(2, 1, 1'b0);
    do_erase(3);
    check_warn("R6");

    // R8: command presented while busy is ignored
    do_read(0, 0, 1'b1);
    do_read(1, 5, 1'b0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 0);
    finish_run();
  end

endmodule